// File: doc/BRIEF.md
# Interlocked Four-Phase Read Link

This block joins a bus requester and a memory-side responder that share no bus-cycle timing. The only thing that orders a read transfer is the pair of handshake lines between them: a request line driven by the requester and an acknowledge line driven by the responder. Each side reacts only to an edge it has seen from the other side. A transfer therefore takes as long as the two parties need. A slow memory lengthens it, and no cycle budget or wait-state count is programmed anywhere.

The user pulses `start` with an address. The requester latches the address and places it on the bus, then raises `bus_msyn` one cycle later. The responder sees the request through a two-flop synchronizer, strobes the memory read port and waits for `mem_valid`. It then drives the word onto `bus_data` with `bus_data_oe` high and raises `bus_ssyn`. The requester sees the acknowledge through its own synchronizer and captures the word. In the same cycle it drops the request and pulses `done` with `rd_data`. The responder sees the request fall, then releases the data lines and drops the acknowledge. The requester accepts a new `start` only once it has seen the acknowledge low.

Requester states are IDLE, SETUP, REQ and DROP. Its transitions are:
- IDLE to SETUP on `start` while the synchronized acknowledge is low.
- SETUP to REQ unconditionally.
- REQ to DROP when the synchronized acknowledge is high. This transition also captures the data and fires `done`.
- DROP to IDLE when the synchronized acknowledge is low.

Responder states are IDLE, FETCH and ACK. Its transitions are:
- IDLE to FETCH when the synchronized request is high.
- FETCH to ACK on `mem_valid`, which also latches the memory word.
- ACK to IDLE when the synchronized request is low.

Top module: `async_read_link`

## Requirements
- R1: While reset is asserted, and in the cycle after reset is asserted in the middle of a transfer, `bus_msyn`, `bus_ssyn`, `bus_data_oe`, `mem_rd` and `done` are all 0.
- R2: `bus_msyn` rises only while `bus_ssyn` is 0. When it rises, `bus_addr` already holds the address that was given with `start`.
- R3: `bus_ssyn` rises only while `bus_msyn` is 1, and only after the memory port has returned `mem_valid` during a `mem_rd` strobe.
- R4: `bus_msyn` falls only while `bus_ssyn` is 1. In the cycle it falls, `done` is 1 for exactly one cycle and `rd_data` equals the word the memory returned for that address.
- R5: `bus_ssyn` falls only while `bus_msyn` is 0.
- R6: Whenever `bus_ssyn` is 0, `bus_data_oe` is 0 and `bus_data` reads as all zeros (the released state).
- R7: `bus_addr` does not change while either `bus_msyn` or `bus_ssyn` is 1.
- R8: A `start` pulse that arrives before the requester has seen `bus_ssyn` low is ignored. No new request is raised and `bus_addr` keeps the previous address.
- R9: Each extra cycle the memory takes to raise `mem_valid` lengthens the start-to-`done` time by exactly one cycle.
- R10: `bus_data` stays stable for as long as `bus_data_oe` stays 1.
- R11: `mem_rd` is 1 only while `bus_msyn` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a read transfer of `addr_in` |
| addr_in | input | AW | Address to read |
| rd_data | output | DW | Word captured by the requester |
| done | output | 1 | One-cycle strobe when `rd_data` is valid |
| mem_rd | output | 1 | Memory read strobe from the responder |
| mem_addr | output | AW | Address presented to memory |
| mem_rdata | input | DW | Memory read word |
| mem_valid | input | 1 | Memory word is valid |
| bus_msyn | output | 1 | Request handshake line |
| bus_ssyn | output | 1 | Acknowledge handshake line |
| bus_addr | output | AW | Bus address lines |
| bus_data | output | DW | Bus data lines (zero when released) |
| bus_data_oe | output | 1 | Responder is driving the data lines |

## Verification
On every cycle, the bound checker enforces the ordering of the handshake:
- each sync edge happens only in the allowed state of the opposite line;
- the data lines are released while the acknowledge is low, and hold steady while driven;
- the address holds during the handshake;
- the `done` strobe lines up with the falling request and carries the word on the bus.

The bench scenarios show what no single-cycle property can:
- the captured word is correct for a range of addresses and memory latencies;
- the transfer stretches by exactly the extra latency;
- an early `start` is dropped;
- a reset in the middle of a transfer clears both sides and a later read still completes.

// File: rtl/hs_pkg.sv
package hs_pkg;
    typedef enum logic [1:0] {
        M_IDLE  = 2'd0,
        M_SETUP = 2'd1,
        M_REQ   = 2'd2,
        M_DROP  = 2'd3
    } mst_state_t;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FETCH = 2'd1,
        S_ACK   = 2'd2
    } slv_state_t;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_master.sv
module hs_master
    import hs_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] addr_in,
    input  logic          ssyn_in,
    input  logic [DW-1:0] bus_data,
    output logic          msyn,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] rd_data,
    output logic          done
);
    mst_state_t state, nxt;
    logic          accept;
    logic          capture;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          done_q;

    assign accept  = (state == M_IDLE) && start && !ssyn_in;
    assign capture = (state == M_REQ) && ssyn_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= M_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            M_IDLE:  if (accept)   nxt = M_SETUP;
            M_SETUP:               nxt = M_REQ;
            M_REQ:   if (ssyn_in)  nxt = M_DROP;
            M_DROP:  if (!ssyn_in) nxt = M_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            done_q <= 1'b0;
        end else begin
            if (accept)  addr_q <= addr_in;
            if (capture) data_q <= bus_data;
            done_q <= capture;
        end
    end

    assign msyn     = (state == M_REQ);
    assign bus_addr = addr_q;
    assign rd_data  = data_q;
    assign done     = done_q;
endmodule

// File: rtl/hs_slave.sv
module hs_slave
    import hs_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          msyn_in,
    input  logic [AW-1:0] bus_addr,
    input  logic          mem_valid,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    output logic          ssyn,
    output logic          data_oe,
    output logic [DW-1:0] bus_data
);
    slv_state_t state, nxt;
    logic [DW-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (msyn_in)   nxt = S_FETCH;
            S_FETCH: if (mem_valid) nxt = S_ACK;
            S_ACK:   if (!msyn_in)  nxt = S_IDLE;
            default:                nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              word_q <= '0;
        else if (state == S_FETCH && mem_valid)  word_q <= mem_rdata;
    end

    assign mem_rd   = (state == S_FETCH);
    assign mem_addr = bus_addr;
    assign ssyn     = (state == S_ACK);
    assign data_oe  = ssyn;
    assign bus_data = data_oe ? word_q : '0;
endmodule

// File: rtl/async_read_link.sv
module async_read_link #(
    parameter int AW          = 8,
    parameter int DW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] addr_in,
    output logic [DW-1:0] rd_data,
    output logic          done,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_valid,
    output logic          bus_msyn,
    output logic          bus_ssyn,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_data,
    output logic          bus_data_oe
);
    logic msyn_seen;
    logic ssyn_seen;

    hs_sync #(.STAGES(SYNC_STAGES)) u_sync_req (
        .clk(clk), .rst_n(rst_n), .d(bus_msyn), .q(msyn_seen)
    );

    hs_sync #(.STAGES(SYNC_STAGES)) u_sync_ack (
        .clk(clk), .rst_n(rst_n), .d(bus_ssyn), .q(ssyn_seen)
    );

    hs_master #(.AW(AW), .DW(DW)) u_master (
        .clk(clk), .rst_n(rst_n),
        .start(start), .addr_in(addr_in),
        .ssyn_in(ssyn_seen), .bus_data(bus_data),
        .msyn(bus_msyn), .bus_addr(bus_addr),
        .rd_data(rd_data), .done(done)
    );

    hs_slave #(.AW(AW), .DW(DW)) u_slave (
        .clk(clk), .rst_n(rst_n),
        .msyn_in(msyn_seen), .bus_addr(bus_addr),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata),
        .mem_rd(mem_rd), .mem_addr(mem_addr),
        .ssyn(bus_ssyn), .data_oe(bus_data_oe), .bus_data(bus_data)
    );
endmodule

// File: rtl/hs_read_checker.sv
module hs_read_checker #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic [DW-1:0] rd_data,
    input logic          mem_rd,
    input logic          mem_valid,
    input logic          bus_msyn,
    input logic          bus_ssyn,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_data,
    input logic          bus_data_oe
);
    // R2
    msyn_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_msyn) |-> !bus_ssyn);

    // R3
    ssyn_rise_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ssyn) |-> bus_msyn);

    // R3
    ssyn_rise_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ssyn) |-> $past(mem_rd && mem_valid));

    // R4
    msyn_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_msyn) |-> bus_ssyn);

    // R4
    done_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($fell(bus_msyn) && rd_data == bus_data));

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    ssyn_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_ssyn) |-> !bus_msyn);

    // R6
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ssyn |-> (!bus_data_oe && bus_data == '0));

    // R7
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_msyn || bus_ssyn) |-> $stable(bus_addr));

    // R10
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_data_oe && $past(bus_data_oe)) |-> $stable(bus_data));

    // R11
    mem_rd_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> bus_msyn);
endmodule

bind async_read_link hs_read_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .done(done), .rd_data(rd_data),
    .mem_rd(mem_rd), .mem_valid(mem_valid),
    .bus_msyn(bus_msyn), .bus_ssyn(bus_ssyn), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_data_oe(bus_data_oe)
);

// File: tb/sim_async_read_link.sv
`timescale 1ns/1ps
module sim_async_read_link;
    localparam int AW = 8;
    localparam int DW = 16;

    // each entry: {address, memory latency in cycles}
    localparam logic [15:0] VECS [0:5] = '{
        16'h00_00, 16'hFF_00, 16'h5A_03, 16'hA5_07, 16'h01_01, 16'h80_0C
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [DW-1:0] rd_data;
    logic          done;
    logic          mem_rd;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata;
    logic          mem_valid;
    logic          bus_msyn, bus_ssyn, bus_data_oe;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_data;

    int checks = 0;
    int errors = 0;
    int mem_lat = 0;
    int mem_cnt = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    async_read_link #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .addr_in(addr_in),
        .rd_data(rd_data), .done(done), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_valid(mem_valid),
        .bus_msyn(bus_msyn), .bus_ssyn(bus_ssyn), .bus_addr(bus_addr),
        .bus_data(bus_data), .bus_data_oe(bus_data_oe)
    );

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        return {a ^ 8'h3C, ~a};
    endfunction

    // memory model: word valid after mem_lat cycles of read strobe
    always_ff @(posedge clk) begin
        if (!mem_rd) mem_cnt <= 0;
        else         mem_cnt <= mem_cnt + 1;
    end
    assign mem_valid = mem_rd && (mem_cnt >= mem_lat);
    assign mem_rdata = mem_word(mem_addr);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual run too long, expected end before 100000 cycles");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // one read; returns cycles from start to done
    task automatic do_read(input logic [AW-1:0] a, input int lat, output int n);
        logic pm;
        mem_lat = lat;
        @(negedge clk);
        addr_in = a;
        start = 1'b1;
        n = 0;
        pm = bus_msyn;
        tick();
        n++;
        start = 1'b0;
        while (!done && n < 300) begin
            if (bus_msyn && !pm) begin
                chk("R2 ssyn low at request", {31'd0, bus_ssyn}, 32'd0);
                chk("R2 address presented", {24'd0, bus_addr}, {24'd0, a});
            end
            if (!bus_ssyn)
                chk("R6 released data", {15'd0, bus_data_oe, bus_data}, 32'd0);
            pm = bus_msyn;
            tick();
            n++;
        end
        chk("R4 done seen", {31'd0, done}, 32'd1);
        chk("R4 request dropped at done", {31'd0, bus_msyn}, 32'd0);
        chk("R4 captured word", {16'd0, rd_data}, {16'd0, mem_word(a)});
        tick();
        chk("R4 done one cycle", {31'd0, done}, 32'd0);
        while (bus_ssyn) begin
            chk("R5 request low while ack high", {31'd0, bus_msyn}, 32'd0);
            chk("R7 address held", {24'd0, bus_addr}, {24'd0, a});
            tick();
        end
        repeat (4) tick();
    endtask

    initial begin
        int n0;
        int n;
        logic [AW-1:0] a;
        int l;

        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {27'd0, bus_msyn, bus_ssyn, bus_data_oe, mem_rd, done}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        n0 = 0;
        for (int i = 0; i < 6; i++) begin
            a = VECS[i][15:8];
            l = int'(VECS[i][7:0]);
            do_read(a, l, n);
            if (i == 0) n0 = n;
            else chk("R9 latency stretch", n, n0 + l);
        end

        // R8: start while ack still high is ignored
        mem_lat = 2;
        @(negedge clk);
        addr_in = 8'h33;
        start = 1'b1;
        tick();
        start = 1'b0;
        while (!done) tick();
        chk("R4 word before ignored start", {16'd0, rd_data}, {16'd0, mem_word(8'h33)});
        addr_in = 8'hC7;
        start = 1'b1;
        tick();
        start = 1'b0;
        begin
            int rises = 0;
            logic pm = bus_msyn;
            for (int k = 0; k < 40; k++) begin
                if (bus_msyn && !pm) rises++;
                pm = bus_msyn;
                tick();
            end
            chk("R8 no new request", rises, 0);
            chk("R8 address unchanged", {24'd0, bus_addr}, 32'h33);
        end

        // R1: reset in the middle of a transfer
        mem_lat = 20;
        @(negedge clk);
        addr_in = 8'h4E;
        start = 1'b1;
        tick();
        start = 1'b0;
        repeat (8) tick();
        chk("R11 read strobe under request", {30'd0, mem_rd, bus_msyn}, 32'd3);
        rst_n = 1'b0;
        #1;
        chk("R1 mid-transfer reset", {27'd0, bus_msyn, bus_ssyn, bus_data_oe, mem_rd, done}, 32'd0);
        tick();
        chk("R1 held in reset", {27'd0, bus_msyn, bus_ssyn, bus_data_oe, mem_rd, done}, 32'd0);
        rst_n = 1'b1;
        repeat (3) tick();
        do_read(8'h6B, 1, n);
        chk("R9 recovery latency", n, n0 + 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule